// File: doc/BRIEF.md
# Three-Source Interrupt Controller with Set/Clear Enables

This block collects interrupt requests from three sources in a tile-based graphics engine and presents them to a host through a small single-cycle register port. Two of the sources are one-cycle event pulses: the end of a rendered frame and the end of a binning flush. The third is a level condition, raised while the binner has run out of memory. Each source has a pending bit in a status register. The host acknowledges a pending bit by writing 1 to it.

Enables are never written directly. One register address sets enable bits and another clears them, and 0 bits written to either leave the enables alone. A read of either address returns the current enable mask. The single interrupt output is the registered OR of all pending bits that are also enabled.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all status bits, all enables and `irq_out` are 0.
- R2: A pulse on `evt_frame_done` sets status bit 0, and a pulse on `evt_flush_done` sets status bit 1, whatever the enable state. The bits hold until acknowledged. Status is read at address 0.
- R3: A write to address 0 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: When an event pulse and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R5: Status bit 2 tracks `oom_level`. An acknowledge while the level is still high makes the bit read 0 for exactly one cycle, and the bit is set again after that. Once the level is low, an acknowledge keeps the bit at 0.
- R6: A write to address 1 enables each source whose data bit is 1. Data bits that are 0 leave the enables unchanged.
- R7: A write to address 2 disables each source whose data bit is 1. Data bits that are 0 leave the enables unchanged.
- R8: Reads at address 1 and address 2 both return the enable mask in bits 2:0. A read at address 3 returns 0.
- R9: `irq_out` equals, one clock later, whether any bit of (status AND enable) was 1. Enabling a source that is already pending therefore raises `irq_out` on the next clock.
- R10: Data bits 31:3 are ignored on every write, and those bits read as 0 at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_frame_done | input | 1 | Frame-done event pulse |
| evt_flush_done | input | 1 | Binning-flush-done event pulse |
| oom_level | input | 1 | Binner out-of-memory level condition |
| irq_out | output | 1 | Combined interrupt request to the host |

## Verification
The bench targets an event pulse that coincides with its own acknowledge. A design that lets the clear win here loses a frame or flush completion. It holds the out-of-memory level high across several acknowledges. A design that treats this bit as a latched pulse would keep it at 0, and a design that ignores the clear would never show the one-cycle low. It writes 0 bits to the set and clear addresses and sets the upper data bits. A design that loads the enables directly would wipe the mask, and one that stores the upper bits would read them back. It also enables a source only after that source is already pending. If the output were gated at latch time, or timed off by a cycle, that case would show it.

// File: rtl/irq_pkg.sv
// Package: irq_pkg
// Shared sizes, the register address map and the source bit positions for
// the interrupt controller. Assumes word addressing on the register port.
package irq_pkg;
    parameter int NUM_SRC = 3;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 2;

    // Source bit positions (host software decodes these)
    parameter int SRC_FRAME = 0;
    parameter int SRC_FLUSH = 1;
    parameter int SRC_OOM   = 2;

    // Sources whose bit follows a level instead of latching a pulse
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 3'b100;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_EN_SET = 2'd1,
        REG_EN_CLR = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/irq_src_bank.sv
// Module: irq_src_bank
// Holds one pending bit per source. A pulse source sets its bit on the
// event, and a new event takes priority over an acknowledge. A level
// source is cleared by an acknowledge and set again on the following
// cycles while its level stays high. Assumes ack_mask is a one-cycle strobe.
module irq_src_bank #(
    parameter int NSRC = 3,
    parameter logic [NSRC-1:0] LEVEL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] ack_mask,
    output logic [NSRC-1:0] pending
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic bit_q;
        if (LEVEL[i]) begin : g_level
            // Level source: acknowledge first, then re-sample the level
            always_ff @(posedge clk) begin
                if (!rst_n)           bit_q <= 1'b0;
                else if (ack_mask[i]) bit_q <= 1'b0;
                else if (src_in[i])   bit_q <= 1'b1;
            end
        end else begin : g_pulse
            // Pulse source: new event wins over a same-cycle acknowledge
            always_ff @(posedge clk) begin
                if (!rst_n)           bit_q <= 1'b0;
                else if (src_in[i])   bit_q <= 1'b1;
                else if (ack_mask[i]) bit_q <= 1'b0;
            end
        end
        assign pending[i] = bit_q;
    end
endmodule

// File: rtl/irq_enable_reg.sv
// Module: irq_enable_reg
// Enable mask, changed only through separate set and clear strobes. The
// address decode guarantees that set and clear never arrive together.
module irq_enable_reg #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_mask,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] enable
);
    logic [NSRC-1:0] en_q;

    // Merge the set bits, then drop the clear bits
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_mask) & ~clr_mask;
    end

    assign enable = en_q;
endmodule

// File: rtl/irq_bus_decode.sv
// Module: irq_bus_decode
// Turns a single-cycle register write into acknowledge, set and clear
// masks, and muxes the read data. Data bits above the source count are
// dropped on writes and read back as 0.
module irq_bus_decode
    import irq_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int DW   = 32,
    parameter int AW   = 2
) (
    input  logic [AW-1:0]   addr,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] pending,
    input  logic [NSRC-1:0] enable,
    output logic [NSRC-1:0] ack_mask,
    output logic [NSRC-1:0] set_mask,
    output logic [NSRC-1:0] clr_mask,
    output logic [DW-1:0]   rdata
);
    localparam int PAD_W = DW - NSRC;

    logic [NSRC-1:0]  wbits;
    logic             unused_wdata_hi;

    assign wbits           = wdata[NSRC-1:0];
    assign unused_wdata_hi = ^wdata[DW-1:NSRC];

    // Route the write data to the mask selected by the address
    always_comb begin
        ack_mask = '0;
        set_mask = '0;
        clr_mask = '0;
        if (we) begin
            case (addr)
                REG_STATUS: ack_mask = wbits;
                REG_EN_SET: set_mask = wbits;
                REG_EN_CLR: clr_mask = wbits;
                default: ;
            endcase
        end
    end

    // Read mux; both enable addresses return the same mask
    always_comb begin
        case (addr)
            REG_STATUS:             rdata = {{PAD_W{1'b0}}, pending};
            REG_EN_SET, REG_EN_CLR: rdata = {{PAD_W{1'b0}}, enable};
            default:                rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl.sv
// Module: irq_ctrl (top)
// Interrupt controller for three engine sources. It contains the pending
// bits, the set/clear enable mask, the register decode and a registered
// combined interrupt output. Assumes one register access per cycle.
module irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_frame_done,
    input  logic              evt_flush_done,
    input  logic              oom_level,
    output logic              irq_out
);
    logic [NUM_SRC-1:0] src_vec;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] ack_mask;
    logic [NUM_SRC-1:0] set_mask;
    logic [NUM_SRC-1:0] clr_mask;
    logic               irq_q;

    // Gather the sources into their bit positions
    always_comb begin
        src_vec            = '0;
        src_vec[SRC_FRAME] = evt_frame_done;
        src_vec[SRC_FLUSH] = evt_flush_done;
        src_vec[SRC_OOM]   = oom_level;
    end

    irq_bus_decode #(.NSRC(NUM_SRC), .DW(DATA_W), .AW(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .pending  (status_q),
        .enable   (enable_q),
        .ack_mask (ack_mask),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .rdata    (bus_rdata)
    );

    irq_src_bank #(.NSRC(NUM_SRC), .LEVEL(LEVEL_MASK)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_vec),
        .ack_mask (ack_mask),
        .pending  (status_q)
    );

    irq_enable_reg #(.NSRC(NUM_SRC)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .enable   (enable_q)
    );

    // Register the combined request toward the host
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & enable_q);
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
// Module: irq_ctrl_chk
// Property checker for irq_ctrl, attached with bind. It observes the ports
// and the pending and enable state of the top module.
module irq_ctrl_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              evt_frame_done,
    input logic              evt_flush_done,
    input logic              oom_level,
    input logic              irq_out,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] enable
);
    // R9: output is the previous cycle's masked pending state
    a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|(status & enable)));

    // R2 and R4: a frame pulse always leaves bit 0 set
    a_r4_frame_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame_done |=> status[SRC_FRAME]);

    // R2 and R4: a flush pulse always leaves bit 1 set
    a_r2_flush_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flush_done |=> status[SRC_FLUSH]);

    // R3: acknowledging bit 1 with no new event clears it
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_STATUS && bus_wdata[SRC_FLUSH] && !evt_flush_done)
        |=> !status[SRC_FLUSH]);

    // R5: acknowledging the level bit drops it for the next cycle
    a_r5_oom_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_STATUS && bus_wdata[SRC_OOM]) |=> !status[SRC_OOM]);

    // R5: a held level with no acknowledge sets the bit
    a_r5_oom_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        (oom_level && !(bus_we && bus_addr == REG_STATUS && bus_wdata[SRC_OOM]))
        |=> status[SRC_OOM]);

    // R6: a set write enables the named source
    a_r6_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_EN_SET && bus_wdata[SRC_FRAME]) |=> enable[SRC_FRAME]);

    // R7: a clear write disables the named source
    a_r7_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_EN_CLR && bus_wdata[SRC_FRAME]) |=> !enable[SRC_FRAME]);

    // R10: upper read bits are always zero
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .evt_frame_done (evt_frame_done),
    .evt_flush_done (evt_flush_done),
    .oom_level      (oom_level),
    .irq_out        (irq_out),
    .status         (status_q),
    .enable         (enable_q)
);

// File: tb/tb_irq_ctrl.sv
// Bench for irq_ctrl: a behavioural reference model is compared with the
// read data and the interrupt output on every clock.
module tb_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        evt_frame_done = 1'b0;
    logic        evt_flush_done = 1'b0;
    logic        oom_level = 1'b0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R1";

    // Reference model state
    bit [2:0] m_st = 0;
    bit [2:0] m_en = 0;
    bit       m_irq = 0;

    always #2.5 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_frame_done(evt_frame_done), .evt_flush_done(evt_flush_done),
        .oom_level(oom_level), .irq_out(irq_out)
    );

    // Reference model, updated from the inputs that stand before each edge
    always @(posedge clk) begin
        bit [2:0] ack;
        bit [2:0] st_n;
        bit [2:0] en_n;
        if (!rst_n) begin
            m_st = 0; m_en = 0; m_irq = 0;
        end else begin
            ack  = (bus_we && bus_addr == 2'd0) ? bus_wdata[2:0] : 3'b000;
            st_n = m_st;
            if (evt_frame_done) st_n[0] = 1; else if (ack[0]) st_n[0] = 0;
            if (evt_flush_done) st_n[1] = 1; else if (ack[1]) st_n[1] = 0;
            if (ack[2]) st_n[2] = 0; else if (oom_level) st_n[2] = 1;
            en_n = m_en;
            if (bus_we && bus_addr == 2'd1) en_n = m_en | bus_wdata[2:0];
            if (bus_we && bus_addr == 2'd2) en_n = m_en & ~bus_wdata[2:0];
            m_irq = (m_st & m_en) != 0;
            m_st  = st_n;
            m_en  = en_n;
        end
    end

    function automatic bit [31:0] model_read(input bit [1:0] a);
        case (a)
            2'd0:       return {29'd0, m_st};
            2'd1, 2'd2: return {29'd0, m_en};
            default:    return 32'd0;
        endcase
    endfunction

    // Compare 2 ns after each rising edge, well clear of both edges
    always @(posedge clk) begin
        #2;
        cycles++;
        checks++;
        if (bus_rdata !== model_read(bus_addr)) begin
            fails++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, bus_addr,
                     bus_rdata, model_read(bus_addr));
        end
        checks++;
        if (irq_out !== m_irq) begin
            fails++;
            $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, m_irq);
        end
    end

    task automatic drive(input logic we, input logic [1:0] a, input logic [31:0] d,
                         input logic fr, input logic fl);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        evt_frame_done = fr; evt_flush_done = fl;
    endtask

    task automatic idle(input logic [1:0] a, input int n);
        for (int i = 0; i < n; i++) drive(1'b0, a, 32'd0, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #400000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit [7:0] lfsr;
        // R1: reset state
        tag = "R1";
        idle(2'd0, 3);
        @(negedge clk); rst_n = 1'b1;
        idle(2'd1, 2);

        // R2: frame pulse latches with enables off; irq stays low (R9)
        tag = "R2";
        drive(0, 2'd0, 0, 1, 0);
        idle(2'd0, 3);
        // R9: enabling a pending source raises irq_out
        tag = "R9";
        drive(1, 2'd1, 32'h1, 0, 0);
        idle(2'd1, 3);
        // R8: both enable addresses read the mask
        tag = "R8";
        idle(2'd2, 2);
        // R6: zero bits to the set address change nothing
        tag = "R6";
        drive(1, 2'd1, 32'h0, 0, 0);
        idle(2'd1, 2);
        // R7: zero bits to the clear address change nothing
        tag = "R7";
        drive(1, 2'd2, 32'h0, 0, 0);
        idle(2'd2, 2);
        // R3: writing 0 keeps status, writing 1 clears it
        tag = "R3";
        drive(1, 2'd0, 32'h0, 0, 0);
        idle(2'd0, 2);
        drive(1, 2'd0, 32'h1, 0, 0);
        idle(2'd0, 3);
        // R4: flush event and its acknowledge in the same cycle
        tag = "R4";
        drive(1, 2'd1, 32'h2, 0, 0);
        drive(1, 2'd0, 32'h2, 0, 1);
        idle(2'd0, 3);
        drive(1, 2'd0, 32'h3, 1, 0);
        idle(2'd0, 3);
        drive(1, 2'd0, 32'h3, 0, 0);
        idle(2'd0, 2);
        // R5: the level source re-asserts after acknowledge while held
        tag = "R5";
        drive(1, 2'd1, 32'h4, 0, 0);
        @(negedge clk); oom_level = 1'b1;
        idle(2'd0, 3);
        drive(1, 2'd0, 32'h4, 0, 0);
        idle(2'd0, 3);
        drive(1, 2'd0, 32'h4, 0, 0);
        drive(1, 2'd0, 32'h4, 0, 0);
        idle(2'd0, 2);
        @(negedge clk); oom_level = 1'b0;
        drive(1, 2'd0, 32'h4, 0, 0);
        idle(2'd0, 4);
        // R10: upper data bits ignored on writes and read as zero
        tag = "R10";
        drive(1, 2'd1, 32'hFFFF_FFF8, 0, 0);
        idle(2'd1, 2);
        drive(1, 2'd0, 32'hFFFF_FFF8, 1, 1);
        idle(2'd0, 2);
        drive(1, 2'd3, 32'hFFFF_FFFF, 0, 0);
        // R8: unused address reads zero
        tag = "R8";
        idle(2'd3, 2);
        // R7: clear writes disable sources and drop irq_out
        tag = "R7";
        drive(1, 2'd2, 32'h7, 0, 0);
        idle(2'd2, 3);
        // R9: pseudo-random mix of events, writes and level changes
        tag = "R9";
        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            @(negedge clk);
            oom_level = lfsr[7] & lfsr[0];
            bus_we = lfsr[1] & lfsr[2];
            bus_addr = lfsr[4:3];
            bus_wdata = {lfsr, lfsr, lfsr, lfsr};
            evt_frame_done = lfsr[5] & lfsr[6];
            evt_flush_done = lfsr[2] & ~lfsr[6];
        end
        idle(2'd0, 3);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule